// File: doc/BRIEF.md
# Timer Compare Unit with Forced Match

This block is an up-counting timer with a single output-compare channel. The counter advances on every cycle where the timer-clock enable `tick` is high. When the counter value equals the compare register on such a tick, the channel records a match. A match sets the interrupt flag and applies the configured output action to the waveform pin. In the clear-on-compare mode, a match also reloads the counter to zero.

Software reaches the counter, the compare value, a control register and a status register through a plain register-bus port. The write side has no handshake and accepts one write per cycle. The read side is combinational from `rd_addr`. Because no data streams through the block, there is no valid/ready interface and no back-pressure.

Two behaviours set this channel apart from a plain comparator:
- **Force strobe.** A write-one strobe in the control register forces an immediate compare event on the pin. It does not touch the interrupt flag or the counter.
- **Match blocking.** Any bus write to the counter blocks the compare on the next timer tick, so a value written equal to the compare register does not match at once.

Top module: `tmr_cmp_unit`

Register addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | counter | counter value |
| 1 | compare | compare value |
| 2 | control | bits [1:0] action, bits [3:2] mode, bit 7 force strobe (write only) |
| 3 | status | bit 0 interrupt flag; writing 1 to bit 0 clears it |

Mode encoding (bits [3:2]): 00 = free-running, 01 = clear-on-compare, 1x = PWM.

## Requirements
- R1: After reset the counter, compare register, control register, pin and flag are all zero.
- R2: On each cycle with `tick` high and no counter write, the counter increments by one, wrapping from all-ones to zero (except as in R4). Without `tick` it holds its value.
- R3: A real match occurs on a cycle with `tick` high, counter equal to the compare register, and no pending block. A real match sets the flag (status bit 0) on that clock edge and applies the output action.
- R4: In clear-on-compare mode (control bits [3:2] = 01), a real match loads the counter with zero instead of incrementing it.
- R5: A bus write to the counter (address 0) suppresses any match on the next cycle with `tick` high. That tick still advances the counter and removes the block.
- R6: The output action in control bits [1:0] acts on the pin as follows: 00 holds it, 01 toggles it, 10 drives it to 0, 11 drives it to 1.
- R7: A control write with bit 7 set, in mode 00 or 01, applies the action bits written in that same write to the pin at that edge. It neither sets the flag nor changes the counter.
- R8: In PWM modes (control bit 3 = 1), a force strobe has no effect on the pin.
- R9: Reading the control register returns the stored action and mode, with bit 7 and every other unused bit as zero.
- R10: Writing 1 to status bit 0 clears the flag. A real match in the same cycle wins and leaves the flag set.
- R11: A counter write in the same cycle as `tick` takes priority: the counter takes the written value.
- R12: A control write takes effect at once: the action and mode it carries govern any match or force evaluated in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cmp_pin | output | 1 | Compare waveform output |
| cmp_flag | output | 1 | Compare-match interrupt flag |

## Verification
The counter is driven in three ways: slow ticking toward the compare value, a write that places it directly on the compare value, and a write combined with a tick. Comparing these separates a real match from a blocked one and write priority from counting.

The force strobe is tried with each of the four action codes, in free-running, clear-on-compare and PWM modes. This shows that forcing moves only the pin, and only outside PWM.

A clear-on-compare run and an all-ones wrap separate the reload path from plain rollover. A long randomized mix of ticks and writes is then compared cycle by cycle against a behavioural model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_CTC   = 2'b01,
    MODE_PWM_A = 2'b10,
    MODE_PWM_B = 2'b11
  } mode_e;

  localparam int ADDR_W     = 2;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STS = 2'd3;

  localparam int CTL_ACT_LSB  = 0;
  localparam int CTL_MODE_LSB = 2;
  localparam int CTL_FORCE    = 7;
  localparam int STS_FLAG     = 0;

  function automatic logic mode_is_pwm(mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] cmp_val,
  input  logic             clr_on_match,
  output logic [WIDTH-1:0] cnt,
  output logic             match_hit
);

  logic [WIDTH-1:0] cnt_q;
  logic             blk_q;
  logic [WIDTH-1:0] cnt_next_tick;

  // a match needs a live tick, an equal compare and no block left by a write
  assign match_hit = tick && !blk_q && (cnt_q == cmp_val);

  always_comb begin
    if (match_hit && clr_on_match) cnt_next_tick = '0;
    else                           cnt_next_tick = cnt_q + WIDTH'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (load) begin
      // the write wins over a tick and arms the block for the next tick
      cnt_q <= load_val;
      blk_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= cnt_next_tick;
      blk_q <= 1'b0;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              match_hit,
  output logic [WIDTH-1:0]  cmp_q,
  output act_e              act_q,
  output mode_e             mode_q,
  output act_e              eff_act,
  output mode_e             eff_mode,
  output logic              force_ev,
  output logic              cnt_ld,
  output logic              flag_q
);

  logic ctl_wr, cmp_wr, sts_wr;
  act_e  wr_act;
  mode_e wr_mode;

  assign ctl_wr = wr_en && (wr_addr == ADDR_CTL);
  assign cmp_wr = wr_en && (wr_addr == ADDR_CMP);
  assign sts_wr = wr_en && (wr_addr == ADDR_STS);
  assign cnt_ld = wr_en && (wr_addr == ADDR_CNT);

  assign wr_act  = act_e'(wr_data[CTL_ACT_LSB +: 2]);
  assign wr_mode = mode_e'(wr_data[CTL_MODE_LSB +: 2]);

  // a control write is seen by this cycle's match and force logic
  assign eff_act  = ctl_wr ? wr_act  : act_q;
  assign eff_mode = ctl_wr ? wr_mode : mode_q;

  // the force strobe is never stored; it only qualifies this write
  assign force_ev = ctl_wr && wr_data[CTL_FORCE] && !mode_is_pwm(wr_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      act_q  <= ACT_HOLD;
      mode_q <= MODE_FREE;
    end else begin
      if (cmp_wr) cmp_q <= wr_data;
      if (ctl_wr) begin
        act_q  <= wr_act;
        mode_q <= wr_mode;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               flag_q <= 1'b0;
    else if (match_hit)                       flag_q <= 1'b1;
    else if (sts_wr && wr_data[STS_FLAG])     flag_q <= 1'b0;
  end

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
#(
  parameter bit PIN_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic event_hit,
  input  act_e act,
  output logic pin
);

  logic pin_q;
  logic pin_d;

  always_comb begin
    pin_d = pin_q;
    if (event_hit) begin
      unique case (act)
        ACT_HOLD:   pin_d = pin_q;
        ACT_TOGGLE: pin_d = !pin_q;
        ACT_CLEAR:  pin_d = 1'b0;
        ACT_SET:    pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= PIN_INIT;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [WIDTH-1:0]  rd_data,
  output logic              cmp_pin,
  output logic              cmp_flag
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cmp_q;
  act_e             act_q, eff_act;
  mode_e            mode_q, eff_mode;
  logic             force_ev, cnt_ld, flag_q, match_hit;
  logic             wave_ev;

  tmr_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .match_hit (match_hit),
    .cmp_q     (cmp_q),
    .act_q     (act_q),
    .mode_q    (mode_q),
    .eff_act   (eff_act),
    .eff_mode  (eff_mode),
    .force_ev  (force_ev),
    .cnt_ld    (cnt_ld),
    .flag_q    (flag_q)
  );

  tmr_count #(.WIDTH(WIDTH)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .load         (cnt_ld),
    .load_val     (wr_data),
    .cmp_val      (cmp_q),
    .clr_on_match (eff_mode == MODE_CTC),
    .cnt          (cnt_q),
    .match_hit    (match_hit)
  );

  assign wave_ev = match_hit || force_ev;

  tmr_wave #(.PIN_INIT(1'b0)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .event_hit (wave_ev),
    .act       (eff_act),
    .pin       (cmp_pin)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADDR_CNT: rd_data = cnt_q;
      ADDR_CMP: rd_data = cmp_q;
      ADDR_CTL: begin
        rd_data[CTL_ACT_LSB  +: 2] = act_q;
        rd_data[CTL_MODE_LSB +: 2] = mode_q;
      end
      ADDR_STS: rd_data[STS_FLAG] = flag_q;
      default:  rd_data = '0;
    endcase
  end

  assign cmp_flag = flag_q;

endmodule

// File: rtl/tmr_cmp_chk.sv
module tmr_cmp_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [1:0]       rd_addr,
  input logic [WIDTH-1:0] rd_data,
  input logic             cmp_pin,
  input logic             cmp_flag,
  input logic             match_hit,
  input logic [WIDTH-1:0] cnt,
  input logic [1:0]       mode
);

  // R3 / R7: only a real match can raise the flag, never a forced one
  a_r3_flag_from_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> $past(match_hit));

  // R5: a counter write leaves no match possible on the following cycle
  a_r5_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> !match_hit);

  // R4: clear-on-compare match reloads zero
  a_r4_ctc_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (match_hit && mode == 2'b01 && !wr_en) |=> (cnt == '0));

  // R8: force strobe in PWM mode leaves the pin alone
  a_r8_pwm_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && wr_data[7] && wr_data[3] && !match_hit)
      |=> $stable(cmp_pin));

  // R2: no tick and no counter write means the counter holds
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wr_en && wr_addr == 2'd0)) |=> $stable(cnt));

  // R9: force bit never reads back as one
  always @(posedge clk) begin
    if (rst_n && rd_addr == 2'd2) begin
      a_r9_force_reads_zero: assert (rd_data[7] == 1'b0);
    end
  end

endmodule

bind tmr_cmp_unit tmr_cmp_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .cmp_pin   (cmp_pin),
  .cmp_flag  (cmp_flag),
  .match_hit (match_hit),
  .cnt       (cnt_q),
  .mode      (mode_q)
);

// File: tb/tb_tmr_cmp_unit.sv
`timescale 1ns/1ps
module tb_tmr_cmp_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       cmp_pin, cmp_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  tmr_cmp_unit dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp_pin(cmp_pin), .cmp_flag(cmp_flag)
  );

  // behavioural reference model
  int m_cnt, m_cmp, m_act, m_mode, m_pin, m_flag, m_blk;

  always @(posedge clk) begin
    int a, md, hit, frc;
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_act = 0; m_mode = 0; m_pin = 0; m_flag = 0; m_blk = 0;
    end else begin
      a   = (wr_en && wr_addr == 2) ? int'(wr_data[1:0]) : m_act;
      md  = (wr_en && wr_addr == 2) ? int'(wr_data[3:2]) : m_mode;
      hit = (tick && m_blk == 0 && m_cnt == m_cmp) ? 1 : 0;
      frc = (wr_en && wr_addr == 2 && wr_data[7] && md < 2) ? 1 : 0;
      if (hit == 1 || frc == 1) begin
        if (a == 1) m_pin = 1 - m_pin;
        else if (a == 2) m_pin = 0;
        else if (a == 3) m_pin = 1;
      end
      if (wr_en && wr_addr == 0) begin
        m_cnt = int'(wr_data); m_blk = 1;
      end else if (tick) begin
        m_blk = 0;
        m_cnt = (hit == 1 && md == 1) ? 0 : (m_cnt + 1) % 256;
      end
      if (hit == 1) m_flag = 1;
      else if (wr_en && wr_addr == 3 && wr_data[0]) m_flag = 0;
      if (wr_en && wr_addr == 1) m_cmp = int'(wr_data);
      if (wr_en && wr_addr == 2) begin m_act = a; m_mode = md; end
    end
  end

  task automatic chk(int act, int exp, string tag);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(cmp_pin),  m_pin,  "R6 pin vs model");
      chk(int'(cmp_flag), m_flag, "R3 flag vs model");
      if (rd_addr == 2'd0) chk(int'(rd_data), m_cnt, "R2 counter vs model");
    end
  end

  task automatic step(bit t, bit we, logic [1:0] ad, logic [7:0] d);
    tick = t; wr_en = we; wr_addr = ad; wr_data = d;
    @(posedge clk); #1;
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] ad, output int v);
    rd_addr = ad; #1; v = int'(rd_data); rd_addr = 2'd0; #1;
  endtask

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk(int'(cmp_pin), 0, "R1 pin after reset");
    chk(int'(cmp_flag), 0, "R1 flag after reset");
    rd(2'd0, v); chk(v, 0, "R1 counter after reset");
    rd(2'd1, v); chk(v, 0, "R1 compare after reset");
    rd(2'd2, v); chk(v, 0, "R1 control after reset");

    // R3 / R6: real match with toggle action
    step(0, 1, 2'd2, 8'h01);
    step(0, 1, 2'd1, 8'd5);
    step(0, 1, 2'd0, 8'd3);
    step(1, 0, 2'd0, 8'd0);
    rd(2'd0, v); chk(v, 4, "R2 counter increments");
    step(0, 0, 2'd0, 8'd0);
    rd(2'd0, v); chk(v, 4, "R2 counter holds without tick");
    step(1, 0, 2'd0, 8'd0);
    step(1, 0, 2'd0, 8'd0);
    chk(int'(cmp_flag), 1, "R3 match sets flag");
    chk(int'(cmp_pin), 1, "R6 toggle on match");
    rd(2'd0, v); chk(v, 6, "R2 counter after match in free mode");

    // R10: clear flag
    step(0, 1, 2'd3, 8'h01);
    chk(int'(cmp_flag), 0, "R10 flag cleared");

    // R7 / R6: forced match with each action, free mode
    step(0, 1, 2'd2, 8'h82);
    chk(int'(cmp_pin), 0, "R7 force clear");
    step(0, 1, 2'd2, 8'h83);
    chk(int'(cmp_pin), 1, "R7 force set");
    step(0, 1, 2'd2, 8'h81);
    chk(int'(cmp_pin), 0, "R7 force toggle");
    step(0, 1, 2'd2, 8'h81);
    step(0, 1, 2'd2, 8'h80);
    chk(int'(cmp_pin), 1, "R7 force hold keeps pin");
    chk(int'(cmp_flag), 0, "R7 force raises no flag");
    rd(2'd0, v); chk(v, 6, "R7 force leaves counter");
    rd(2'd2, v); chk(v, 0, "R9 control reads force bit as zero");

    // R8: force in PWM mode is ignored
    step(0, 1, 2'd2, 8'h89);
    chk(int'(cmp_pin), 1, "R8 PWM force ignored");
    rd(2'd2, v); chk(v, 8'h09, "R9 control readback in PWM mode");

    // R7: force in clear-on-compare mode does not clear counter
    step(0, 1, 2'd2, 8'h85);
    chk(int'(cmp_pin), 0, "R7 force toggle in CTC mode");
    rd(2'd0, v); chk(v, 6, "R7 CTC force keeps counter");

    // R5: counter written onto compare value is blocked next tick
    step(0, 1, 2'd2, 8'h01);
    step(0, 1, 2'd0, 8'd5);
    step(1, 0, 2'd0, 8'd0);
    chk(int'(cmp_flag), 0, "R5 blocked tick no flag");
    chk(int'(cmp_pin), 0, "R5 blocked tick no pin change");
    rd(2'd0, v); chk(v, 6, "R5 blocked tick still counts");

    // R11: write beats tick
    step(1, 1, 2'd0, 8'd9);
    rd(2'd0, v); chk(v, 9, "R11 write priority over tick");

    // R4: clear-on-compare wrap
    step(0, 1, 2'd1, 8'd3);
    step(0, 1, 2'd2, 8'h05);
    step(0, 1, 2'd0, 8'd0);
    repeat (3) step(1, 0, 2'd0, 8'd0);
    rd(2'd0, v); chk(v, 3, "R4 counter reaches compare");
    step(1, 0, 2'd0, 8'd0);
    rd(2'd0, v); chk(v, 0, "R4 CTC reload to zero");
    chk(int'(cmp_flag), 1, "R4 CTC match sets flag");
    chk(int'(cmp_pin), 1, "R4 CTC match toggles pin");

    // R10: match and clear in same cycle, set wins
    step(0, 1, 2'd3, 8'h01);
    repeat (3) step(1, 0, 2'd0, 8'd0);
    step(1, 1, 2'd3, 8'h01);
    chk(int'(cmp_flag), 1, "R10 match beats clear");

    // R12: control write same cycle as match selects new action
    repeat (3) step(1, 0, 2'd0, 8'd0);
    step(1, 1, 2'd2, 8'h02);
    chk(int'(cmp_pin), 0, "R12 new action applies at once");

    // R2: wrap from all ones in free mode
    step(0, 1, 2'd2, 8'h00);
    step(0, 1, 2'd1, 8'd100);
    step(0, 1, 2'd0, 8'hFE);
    step(1, 0, 2'd0, 8'd0);
    step(1, 0, 2'd0, 8'd0);
    rd(2'd0, v); chk(v, 0, "R2 wrap to zero");

    // randomized mix compared against the model
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] ad;
      logic [7:0] d;
      bit t, we;
      t  = ($urandom % 2) == 1;
      we = ($urandom % 4) == 0;
      ad = 2'($urandom % 4);
      d  = 8'($urandom);
      if (ad == 2'd1) d = 8'($urandom % 16);
      if (ad == 2'd0) d = 8'($urandom % 16);
      step(t, we, ad, d);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule